// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block decides, for every backplane pin and every segment pin of a low-multiplex liquid-crystal panel, which bias rail that pin should be connected to at each moment. A host-side timing source pulses `slot_tick` once per backplane time slot. The block walks through the time slots of a frame, gives the selected backplane an extreme rail, and parks the other backplanes on an intermediate rail. It drives each segment so that the voltage across a lit element is the full swing and the voltage across an unlit element stays small. The drive polarity flips on every frame, so the average voltage across every element is zero. A rail switch outside the block turns each 2-bit level code into a voltage.

The block has four drive modes: static (one backplane), and 1:2, 1:3 and 1:4 multiplex. The 1:2 mode can also use half bias. The display pattern arrives as a flat vector with four bits per segment, one bit for each backplane. A mode or bias request only takes effect when a frame starts, so no frame is ever cut short. A display-enable input blanks every pin to the top rail. While blanked, the frame sequencing keeps running.

The slot controller has five states:
- `ST_HOLD` is the post-reset wait.
- `ST_SLOT0` to `ST_SLOT3` are the backplane time slots.

Its transitions are:
- `ST_HOLD -> ST_SLOT0` happens on the first tick and starts frame 0.
- `ST_SLOTk -> ST_SLOTk+1` is a slot advance, taken on a tick while k is below the last slot of the mode.
- `ST_SLOTlast -> ST_SLOT0` is the frame wrap. It flips the polarity and loads the requested configuration. In static mode this is `ST_SLOT0 -> ST_SLOT0` on every tick.
- Without a tick, every state stays where it is.

Top module: `lcd_wave_seq`

## Requirements
- R1: After reset, every backplane and segment code is 2'b00 (VDD). These codes stay 2'b00 until the first `slot_tick`, whatever the data and configuration inputs do.
- R2: Mode encoding is 2'b00 static, 2'b01 1:2, 2'b10 1:3, 2'b11 1:4, giving N = mode+1 slots per frame. Each tick advances one slot, in the order BP0, BP1, BP2, BP3, and wraps after slot N-1. In a multiplex mode, exactly one backplane holds an extreme code during each slot: the backplane of that slot.
- R3: The first frame after leaving hold has polarity 0. The polarity inverts at every frame wrap. The selected backplane is 2'b00 under polarity 0 and 2'b11 under polarity 1.
- R4: Level codes are 00 = VDD, 01 = upper intermediate, 10 = lower intermediate, 11 = VLCD. In multiplex modes with 1/3 bias, a backplane that is not selected outputs the intermediate code nearer the opposite extreme: 2'b10 under polarity 0 and 2'b01 under polarity 1. Backplanes beyond N-1 follow the same rule.
- R5: In a multiplex mode, a segment whose bit for the selected backplane is 1 outputs the extreme opposite the selected backplane: 2'b11 under polarity 0 and 2'b00 under polarity 1.
- R6: In a multiplex mode with 1/3 bias, a segment whose bit is 0 outputs the intermediate code nearer the selected backplane: 2'b01 under polarity 0 and 2'b10 under polarity 1.
- R7: In static mode, the block outputs only codes 00 and 11. All four backplanes carry the same code, and the polarity inverts on every tick. A lit segment is in antiphase with the backplanes; an unlit segment is in phase with them.
- R8: `cfg_half` = 1 selects half bias, but only in 1:2 mode. Under half bias, every intermediate level is emitted as 2'b01 and code 2'b10 never appears. In the other modes `cfg_half` has no effect.
- R9: `cfg_mode` and `cfg_half` are sampled only on the tick that leaves hold or wraps a frame. A change in the middle of a frame does not alter that frame.
- R10: While `disp_en` is 0, every output code is 2'b00, starting one clock after `disp_en` falls. Slot and polarity sequencing continue while blanked.
- R11: The data bit for segment i and backplane j is `seg_data[4*i+j]`. Segment i drives `seg_lvl[2*i+1:2*i]` and backplane j drives `bp_lvl[2*j+1:2*j]`. The outputs are registered: a tick, a data change or a `disp_en` change appears one clock after the controller state or input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_tick | input | 1 | One-cycle pulse that advances one backplane time slot |
| cfg_mode | input | 2 | Requested drive mode (00 static, 01 1:2, 10 1:3, 11 1:4) |
| cfg_half | input | 1 | Requested half bias (honoured in 1:2 only) |
| disp_en | input | 1 | Display enable; 0 blanks all outputs to VDD |
| seg_data | input | 4*SEG_N | Display pattern, bit 4*i+j = segment i on backplane j |
| bp_lvl | output | 8 | Level code per backplane, 2 bits each |
| seg_lvl | output | 2*SEG_N | Level code per segment, 2 bits each |

## Verification
The embedded properties watch four structural rules on every clock:
- the slot index never exceeds the slot count of the latched mode;
- configuration and polarity only move on entry to slot 0;
- blanking forces all codes to VDD;
- in multiplex, exactly one backplane is at an extreme, half bias never emits the lower-intermediate code, and static mode never emits an intermediate code.

Some behaviours only the bench scenarios can show: the exact code of every pin in each slot and polarity, the bit-to-slot mapping of the data, the deferral of a mid-frame mode change, and the resumption of the correct slot after blanking.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    localparam int BP_COUNT = 4;
    localparam int BP_IDX_W = $clog2(BP_COUNT);

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_2      = 2'd1,
        MUX_3      = 2'd2,
        MUX_4      = 2'd3
    } mux_mode_e;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_SLOT0 = 3'd1,
        ST_SLOT1 = 3'd2,
        ST_SLOT2 = 3'd3,
        ST_SLOT3 = 3'd4
    } slot_state_e;

    typedef logic [1:0] level_t;

    localparam level_t LV_VDD       = 2'b00;
    localparam level_t LV_UPPER_MID = 2'b01;
    localparam level_t LV_LOWER_MID = 2'b10;
    localparam level_t LV_VLCD      = 2'b11;

    // extreme rail for a given polarity (0 -> VDD, 1 -> VLCD)
    function automatic level_t extreme_level(input logic pol);
        return pol ? LV_VLCD : LV_VDD;
    endfunction

    // intermediate rail; under half bias there is only one
    function automatic level_t mid_level(input logic near_vlcd, input logic half);
        if (half) return LV_UPPER_MID;
        return near_vlcd ? LV_LOWER_MID : LV_UPPER_MID;
    endfunction

endpackage

// File: rtl/lcdw_slot_fsm.sv
module lcdw_slot_fsm
    import lcdw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot_tick,
    input  mux_mode_e           cfg_mode,
    input  logic                cfg_half,
    output slot_state_e         state_o,
    output logic [BP_IDX_W-1:0] slot_idx_o,
    output logic                pol_o,
    output mux_mode_e           mode_o,
    output logic                half_o
);

    slot_state_e state_q, state_d;
    logic        pol_q, pol_d;
    mux_mode_e   mode_q, mode_d;
    logic        half_q, half_d;
    logic [BP_IDX_W-1:0] last_slot;
    logic [BP_IDX_W-1:0] slot_idx;

    assign last_slot = BP_IDX_W'(mode_q);

    // next-state and frame-boundary loading
    always_comb begin
        state_d = state_q;
        pol_d   = pol_q;
        mode_d  = mode_q;
        half_d  = half_q;
        if (slot_tick) begin
            unique case (state_q)
                ST_HOLD: begin
                    state_d = ST_SLOT0;
                    pol_d   = 1'b0;
                    mode_d  = cfg_mode;
                    half_d  = cfg_half;
                end
                ST_SLOT0: state_d = (last_slot == 2'd0) ? ST_SLOT0 : ST_SLOT1;
                ST_SLOT1: state_d = (last_slot == 2'd1) ? ST_SLOT0 : ST_SLOT2;
                ST_SLOT2: state_d = (last_slot == 2'd2) ? ST_SLOT0 : ST_SLOT3;
                ST_SLOT3: state_d = ST_SLOT0;
                default:  state_d = ST_HOLD;
            endcase
            if (state_q != ST_HOLD && state_d == ST_SLOT0) begin
                pol_d  = ~pol_q;
                mode_d = cfg_mode;
                half_d = cfg_half;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            pol_q   <= 1'b0;
            mode_q  <= MUX_4;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pol_q   <= pol_d;
            mode_q  <= mode_d;
            half_q  <= half_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SLOT1: slot_idx = 2'd1;
            ST_SLOT2: slot_idx = 2'd2;
            ST_SLOT3: slot_idx = 2'd3;
            default:  slot_idx = 2'd0;
        endcase
    end

    assign state_o    = state_q;
    assign slot_idx_o = slot_idx;
    assign pol_o      = pol_q;
    assign mode_o     = mode_q;
    assign half_o     = half_q;

    // R2: the active slot never lies beyond the latched mode's last slot
    assert_slot_within_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HOLD) |-> (slot_idx <= last_slot));

    // R9: configuration moves only on entering slot 0
    assert_cfg_at_frame_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_q) || !$stable(half_q)) |-> (state_q == ST_SLOT0));

    // R3: polarity flips only on a frame wrap
    assert_pol_at_frame_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_q) |-> (state_q == ST_SLOT0 && $past(state_q) != ST_HOLD));

endmodule

// File: rtl/lcdw_level_gen.sv
module lcdw_level_gen
    import lcdw_pkg::*;
#(
    parameter int SEG_N = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_en,
    input  slot_state_e             state_i,
    input  logic [BP_IDX_W-1:0]     slot_idx_i,
    input  logic                    pol_i,
    input  mux_mode_e               mode_i,
    input  logic                    half_i,
    input  logic [BP_COUNT*SEG_N-1:0] seg_data,
    output logic [2*BP_COUNT-1:0]   bp_lvl,
    output logic [2*SEG_N-1:0]      seg_lvl
);

    logic   active, half_eff, is_static;
    level_t sel_lv, opp_lv, idle_bp_lv, seg_off_lv;
    logic [2*BP_COUNT-1:0] bp_d, bp_q;
    logic [2*SEG_N-1:0]    seg_d, seg_q;

    assign active     = disp_en && (state_i != ST_HOLD);
    assign half_eff   = half_i && (mode_i == MUX_2);
    assign is_static  = (mode_i == MUX_STATIC);
    assign sel_lv     = extreme_level(pol_i);
    assign opp_lv     = extreme_level(~pol_i);
    // unselected backplane: intermediate nearer the opposite extreme
    assign idle_bp_lv = is_static ? sel_lv : mid_level(~pol_i, half_eff);
    // unlit segment: intermediate nearer the selected backplane
    assign seg_off_lv = is_static ? sel_lv : mid_level(pol_i, half_eff);

    genvar j;
    generate
        for (j = 0; j < BP_COUNT; j++) begin : g_bp
            assign bp_d[2*j +: 2] = !active ? LV_VDD :
                                    (slot_idx_i == BP_IDX_W'(j)) ? sel_lv : idle_bp_lv;
        end
    endgenerate

    genvar i;
    generate
        for (i = 0; i < SEG_N; i++) begin : g_seg
            logic [BP_COUNT-1:0] nib;
            assign nib = seg_data[BP_COUNT*i +: BP_COUNT];
            assign seg_d[2*i +: 2] = !active ? LV_VDD :
                                     nib[slot_idx_i] ? opp_lv : seg_off_lv;
        end
    endgenerate

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q  <= '0;
            seg_q <= '0;
        end else begin
            bp_q  <= bp_d;
            seg_q <= seg_d;
        end
    end

    assign bp_lvl  = bp_q;
    assign seg_lvl = seg_q;

    // observation of the registered codes
    logic [BP_COUNT-1:0] obs_bp_ext;
    logic obs_any_lower, obs_any_mid, obs_all_vdd;
    always_comb begin
        obs_any_lower = 1'b0;
        obs_any_mid   = 1'b0;
        obs_all_vdd   = (bp_q == '0) && (seg_q == '0);
        for (int k = 0; k < BP_COUNT; k++) begin
            obs_bp_ext[k] = (bp_q[2*k +: 2] == LV_VDD) || (bp_q[2*k +: 2] == LV_VLCD);
            if (bp_q[2*k +: 2] == LV_LOWER_MID) obs_any_lower = 1'b1;
            if (bp_q[2*k +: 2] == LV_LOWER_MID || bp_q[2*k +: 2] == LV_UPPER_MID) obs_any_mid = 1'b1;
        end
        for (int k = 0; k < SEG_N; k++) begin
            if (seg_q[2*k +: 2] == LV_LOWER_MID) obs_any_lower = 1'b1;
            if (seg_q[2*k +: 2] == LV_LOWER_MID || seg_q[2*k +: 2] == LV_UPPER_MID) obs_any_mid = 1'b1;
        end
    end

    assert_blank_all_vdd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> obs_all_vdd);

    assert_one_selected_bp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !is_static) |=> ($countones(obs_bp_ext) == 1));

    assert_half_no_lower_mid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && half_eff) |=> !obs_any_lower);

    assert_static_two_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_static) |=> !obs_any_mid);

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq #(
    parameter int SEG_N = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_tick,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_half,
    input  logic                 disp_en,
    input  logic [4*SEG_N-1:0]   seg_data,
    output logic [7:0]           bp_lvl,
    output logic [2*SEG_N-1:0]   seg_lvl
);
    import lcdw_pkg::*;

    slot_state_e         state;
    logic [BP_IDX_W-1:0] slot_idx;
    logic                pol;
    mux_mode_e           mode;
    logic                half;

    lcdw_slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_tick  (slot_tick),
        .cfg_mode   (mux_mode_e'(cfg_mode)),
        .cfg_half   (cfg_half),
        .state_o    (state),
        .slot_idx_o (slot_idx),
        .pol_o      (pol),
        .mode_o     (mode),
        .half_o     (half)
    );

    lcdw_level_gen #(.SEG_N(SEG_N)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_en    (disp_en),
        .state_i    (state),
        .slot_idx_i (slot_idx),
        .pol_i      (pol),
        .mode_i     (mode),
        .half_i     (half),
        .seg_data   (seg_data),
        .bp_lvl     (bp_lvl),
        .seg_lvl    (seg_lvl)
    );

endmodule

// File: tb/lcd_wave_seq_test.sv
`timescale 1ns/1ps
module lcd_wave_seq_test;
    localparam int SEG_N = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_tick = 1'b0;
    logic [1:0] cfg_mode = 2'd3;
    logic cfg_half = 1'b0;
    logic disp_en = 1'b1;
    logic [4*SEG_N-1:0] seg_data = '0;
    logic [7:0] bp_lvl;
    logic [2*SEG_N-1:0] seg_lvl;

    always #4 clk = ~clk;

    lcd_wave_seq #(.SEG_N(SEG_N)) uut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .cfg_mode(cfg_mode),
        .cfg_half(cfg_half), .disp_en(disp_en), .seg_data(seg_data),
        .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
    );

    int checks = 0;
    int failures = 0;

    // requirement-level model of the sequencing
    logic m_hold = 1'b1;
    int   m_slot = 0;
    logic m_pol  = 1'b0;
    int   m_mode = 3;
    logic m_half = 1'b0;

    task automatic model_tick();
        if (m_hold) begin
            m_hold = 1'b0; m_slot = 0; m_pol = 1'b0; m_mode = cfg_mode; m_half = cfg_half;
        end else if (m_slot == m_mode) begin
            m_slot = 0; m_pol = ~m_pol; m_mode = cfg_mode; m_half = cfg_half;
        end else begin
            m_slot++;
        end
    endtask

    function automatic logic [1:0] ex_bp(int j);
        logic he;
        if (!disp_en || m_hold) return 2'b00;
        he = m_half && (m_mode == 1);
        if (m_mode == 0 || j == m_slot) return m_pol ? 2'b11 : 2'b00;
        if (he) return 2'b01;
        return m_pol ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] ex_seg(int i);
        logic he;
        if (!disp_en || m_hold) return 2'b00;
        he = m_half && (m_mode == 1);
        if (seg_data[4*i + m_slot]) return m_pol ? 2'b00 : 2'b11;
        if (m_mode == 0) return m_pol ? 2'b11 : 2'b00;
        if (he) return 2'b01;
        return m_pol ? 2'b10 : 2'b01;
    endfunction

    task automatic check_all(string tag);
        logic [7:0] eb;
        logic [2*SEG_N-1:0] es;
        for (int j = 0; j < 4; j++) eb[2*j +: 2] = ex_bp(j);
        for (int i = 0; i < SEG_N; i++) es[2*i +: 2] = ex_seg(i);
        checks += 2;
        if (bp_lvl !== eb) begin
            failures++;
            $display("FAIL %s backplanes actual=%h expected=%h", tag, bp_lvl, eb);
        end
        if (seg_lvl !== es) begin
            failures++;
            $display("FAIL %s segments actual=%h expected=%h", tag, seg_lvl, es);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) slot_tick = 1'b1;
        @(negedge clk) slot_tick = 1'b0;
        model_tick();
        @(negedge clk);
    endtask

    // {mode[1:0], half, tick count[4:0]}
    localparam logic [7:0] VECS [8] = '{
        {2'd3, 1'b0, 5'd9}, {2'd2, 1'b0, 5'd7}, {2'd1, 1'b0, 5'd5}, {2'd1, 1'b1, 5'd6},
        {2'd2, 1'b1, 5'd7}, {2'd0, 1'b1, 5'd5}, {2'd3, 1'b1, 5'd9}, {2'd0, 1'b0, 5'd4}
    };

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");
        seg_data = {5{32'hA5C3_0F69}};
        cfg_mode = 2'd1;
        repeat (3) @(negedge clk);
        check_all("R1 hold before first tick");

        for (int v = 0; v < 8; v++) begin
            cfg_mode = VECS[v][7:6];
            cfg_half = VECS[v][5];
            seg_data = {5{32'hA5C3_0F69 ^ (32'h1357_9BDF * (v + 1))}};
            if (VECS[v][7:6] == 2'd0) tag = "R7 static";
            else if (VECS[v][5] && VECS[v][7:6] == 2'd1) tag = "R8 half bias 1:2";
            else if (VECS[v][5]) tag = "R8 half ignored R2 R3 R4 R5 R6";
            else tag = "R2 R3 R4 R5 R6 R11";
            for (int t = 0; t < int'(VECS[v][4:0]); t++) begin
                do_tick();
                check_all(tag);
            end
        end

        // R9: mid-frame mode change deferred to the frame wrap
        cfg_mode = 2'd3; cfg_half = 1'b0;
        while (!(m_mode == 3 && m_slot == 0 && !m_hold)) do_tick();
        do_tick();
        cfg_mode = 2'd0;
        do_tick(); check_all("R9 mid-frame slot2 keeps 1:4");
        do_tick(); check_all("R9 mid-frame slot3 keeps 1:4");
        do_tick(); check_all("R9 static from frame wrap");
        do_tick(); check_all("R9 static second tick");

        // R10: blanking and resumption
        cfg_mode = 2'd2;
        do_tick(); do_tick();
        disp_en = 1'b0;
        @(negedge clk); check_all("R10 blanked");
        do_tick(); check_all("R10 tick while blanked");
        do_tick(); check_all("R10 second tick while blanked");
        disp_en = 1'b1;
        @(negedge clk); check_all("R10 resume slot and polarity");

        // R11: data change without a tick, one clock latency
        seg_data = '1;
        @(negedge clk); check_all("R11 all lit");
        seg_data = '0;
        seg_data[4*39 + m_slot] = 1'b1;
        @(negedge clk); check_all("R11 single bit segment 39");

        summary();
        $finish;
    end
endmodule